// File: doc/BRIEF.md
# Privilege-Selected Pointer Mask Registers

This block is a small bank of control registers for pointer masking. It stores a mask and a base value for each of the three privilege levels (machine, supervisor, user), together with one control register. The control register holds an enable bit per level, a hardwired-zero instruction-masking bit per level, a two-bit extension state and a flag marking machine-level masking as current. From these registers, the active privilege level, the 32-bit mode input and an extension-present input, the block drives a registered current mask and base pair. The address path that applies the pair uses these two outputs.

Software writes the registers through a single write port (address, data, strobe) and reads them back through a combinational read port that shares the address. Any write to a mapped register moves the extension-state machine to DIRTY and raises two sticky status flags. The flags are meant for the XS and SD fields of the machine status register.

The extension state is a four-state machine: OFF, INITIAL, CLEAN, DIRTY. Reset enters INITIAL. A mapped write takes OFF, INITIAL or CLEAN to DIRTY. DIRTY holds until reset. Without a write, every state holds. No event inside this block leads to OFF or CLEAN.

Top module: `ptrmask_csr_bank`

Address map (3-bit address): 0 control; 1 machine mask; 2 machine base; 3 supervisor mask; 4 supervisor base; 5 user mask; 6 user base; 7 unmapped. Privilege encoding: 2'b11 machine, 2'b01 supervisor, 2'b00 user, 2'b10 reserved. Control layout: bit0 machine enable, bit1 supervisor enable, bit2 user enable, bits 5:3 instruction-masking enables (machine, supervisor, user), bits 7:6 extension state (00 OFF, 01 INITIAL, 10 CLEAN, 11 DIRTY), bit8 machine-current flag, all higher bits zero.

## Requirements
- R1: While reset is held, cur_mask is all ones and cur_base is zero. The control register reads 0x140: extension state INITIAL (01), machine-current flag 1, all enables 0. Both status flags are 0.
- R2: Each of the six mask and base registers keeps its own value and reads back at its address.
- R3: When the extension is present and the enable bit of the active level is set, cur_mask and cur_base show that level's mask and base from the next clock edge.
- R4: When ext_present is 0, or the enable bit of the active level is clear, cur_mask is all ones and cur_base is zero after the next edge.
- R5: The reserved privilege encoding 2'b10 gives cur_mask all ones and cur_base zero after the next edge.
- R6: When xlen32 is 1, bits 63:32 of cur_mask and cur_base are zero after the next edge, and bits 31:0 are unchanged.
- R7: A change of privilege level, of xlen32, or of the control register is reflected in the current pair at the next edge.
- R8: A write to the mask or base register of the active, enabled level updates the current pair at the next edge. This also holds when the privilege level switches to that level in the same cycle. A write to an inactive level's register leaves the pair unchanged.
- R9: Any write to addresses 0 to 6 sets the extension state to DIRTY (bits 7:6 = 11) and sets st_xs_dirty and st_sd_dirty from the next edge.
- R10: Control bits 5:3 always read 0, whatever value is written to them.
- R11: Address 7 reads zero. A write to it changes no register, no extension state and no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe |
| csr_addr | input | 3 | Register address for read and write |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for csr_addr |
| priv | input | 2 | Active privilege level |
| xlen32 | input | 1 | 1 when running in 32-bit mode |
| ext_present | input | 1 | 1 when the masking extension is implemented |
| cur_mask | output | 64 | Registered current mask |
| cur_base | output | 64 | Registered current base |
| st_xs_dirty | output | 1 | Sticky flag for the status XS field |
| st_sd_dirty | output | 1 | Sticky flag for the status SD field |

## Verification
A register write and a privilege switch can land in the same cycle. The critical case is a write to the mask of the level being entered. The bench drives priv to supervisor and, on the same edge, writes a new supervisor mask. The scoreboard expects the new mask on cur_mask one edge later, with no stale value in between. A second overlap writes the control register to disable the active level while that level stays selected; identity values must follow on the next edge.

// File: rtl/ptrmask_pkg.sv
package ptrmask_pkg;
    typedef enum logic [1:0] {
        EXT_OFF   = 2'b00,
        EXT_INIT  = 2'b01,
        EXT_CLEAN = 2'b10,
        EXT_DIRTY = 2'b11
    } ext_state_e;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    localparam int NUM_LVL  = 3;
    localparam int LVL_M    = 0;
    localparam int LVL_S    = 1;
    localparam int LVL_U    = 2;

    localparam int CTRL_W       = 9;
    localparam int BIT_EN_LO    = 0;
    localparam int BIT_INSN_LO  = 3;
    localparam int BIT_EXT_LO   = 6;
    localparam int BIT_MCUR     = 8;

    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_FIRST   = 1;
    localparam int ADDR_LIMIT   = ADDR_FIRST + 2 * NUM_LVL;
endpackage

// File: rtl/ptrmask_ctrl.sv
module ptrmask_ctrl
    import ptrmask_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic                 wr_any,
    input  logic [NUM_LVL-1:0]   wen_val,
    input  logic                 wmcur_val,
    output logic [NUM_LVL-1:0]   en_nxt,
    output logic [CTRL_W-1:0]    ctrl_rd,
    output logic                 xs_flag,
    output logic                 sd_flag
);
    ext_state_e           state_q, state_d;
    logic [NUM_LVL-1:0]   en_q;
    logic                 mcur_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_OFF, EXT_INIT, EXT_CLEAN: if (wr_any) state_d = EXT_DIRTY;
            EXT_DIRTY:                    state_d = EXT_DIRTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EXT_INIT;
            en_q    <= '0;
            mcur_q  <= 1'b1;
            xs_flag <= 1'b0;
            sd_flag <= 1'b0;
        end else begin
            state_q <= state_d;
            en_q    <= en_nxt;
            if (wr_ctrl) mcur_q <= wmcur_val;
            if (wr_any) begin
                xs_flag <= 1'b1;
                sd_flag <= 1'b1;
            end
        end
    end

    assign en_nxt = wr_ctrl ? wen_val : en_q;

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[BIT_EN_LO +: NUM_LVL]   = en_q;
        ctrl_rd[BIT_INSN_LO +: NUM_LVL] = '0;
        ctrl_rd[BIT_EXT_LO +: 2]        = state_q;
        ctrl_rd[BIT_MCUR]               = mcur_q;
    end

    AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> (state_q == EXT_DIRTY) && xs_flag && sd_flag); // R9
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        xs_flag |=> xs_flag && sd_flag); // R9
endmodule

// File: rtl/ptrmask_bank.sv
module ptrmask_bank #(
    parameter int XLEN    = 64,
    parameter int NUM_LVL = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_LVL-1:0]                wr_mask,
    input  logic [NUM_LVL-1:0]                wr_base,
    input  logic [XLEN-1:0]                   wdata,
    output logic [NUM_LVL-1:0][XLEN-1:0]      mask_q,
    output logic [NUM_LVL-1:0][XLEN-1:0]      base_q,
    output logic [NUM_LVL-1:0][XLEN-1:0]      mask_nxt,
    output logic [NUM_LVL-1:0][XLEN-1:0]      base_nxt
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign mask_nxt[l] = wr_mask[l] ? wdata : mask_q[l];
        assign base_nxt[l] = wr_base[l] ? wdata : base_q[l];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[l] <= '0;
                base_q[l] <= '0;
            end else begin
                mask_q[l] <= mask_nxt[l];
                base_q[l] <= base_nxt[l];
            end
        end

        AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_mask[l] |=> $stable(mask_q[l])); // R2
        AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_base[l] |=> $stable(base_q[l])); // R2
    end
endmodule

// File: rtl/ptrmask_select.sv
module ptrmask_select
    import ptrmask_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        priv,
    input  logic                              xlen32,
    input  logic                              ext_present,
    input  logic [NUM_LVL-1:0]                en_nxt,
    input  logic [NUM_LVL-1:0][XLEN-1:0]      mask_nxt,
    input  logic [NUM_LVL-1:0][XLEN-1:0]      base_nxt,
    output logic [XLEN-1:0]                   cur_mask,
    output logic [XLEN-1:0]                   cur_base
);
    localparam int HALF = 32;

    logic [1:0]       lvl;
    logic             lvl_ok;
    logic [XLEN-1:0]  pick_mask, pick_base, sel_mask, sel_base;

    always_comb begin
        lvl    = 2'(LVL_M);
        lvl_ok = 1'b1;
        unique case (priv_e'(priv))
            PRIV_M:    lvl = 2'(LVL_M);
            PRIV_S:    lvl = 2'(LVL_S);
            PRIV_U:    lvl = 2'(LVL_U);
            PRIV_RSVD: lvl_ok = 1'b0;
        endcase
        pick_mask = '1;
        pick_base = '0;
        if (ext_present && lvl_ok && en_nxt[lvl]) begin
            pick_mask = mask_nxt[lvl];
            pick_base = base_nxt[lvl];
        end
    end

    if (XLEN > HALF) begin : g_trunc
        always_comb begin
            sel_mask = pick_mask;
            sel_base = pick_base;
            if (xlen32) begin
                sel_mask[XLEN-1:HALF] = '0;
                sel_base[XLEN-1:HALF] = '0;
            end
        end
        AST_RV32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            xlen32 |=> (cur_mask[XLEN-1:HALF] == '0) && (cur_base[XLEN-1:HALF] == '0)); // R6
    end else begin : g_notrunc
        assign sel_mask = pick_mask;
        assign sel_base = pick_base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mask <= '1;
            cur_base <= '0;
        end else begin
            cur_mask <= sel_mask;
            cur_base <= sel_base;
        end
    end

    AST_NO_EXT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_present |=> (&cur_mask[HALF-1:0]) && (cur_base == '0)); // R4
    AST_RSVD_PRIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == PRIV_RSVD) |=> (&cur_mask[HALF-1:0]) && (cur_base == '0)); // R5
endmodule

// File: rtl/ptrmask_csr_bank.sv
module ptrmask_csr_bank
    import ptrmask_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [ADDR_W-1:0]  csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    input  logic [1:0]         priv,
    input  logic               xlen32,
    input  logic               ext_present,
    output logic [XLEN-1:0]    cur_mask,
    output logic [XLEN-1:0]    cur_base,
    output logic               st_xs_dirty,
    output logic               st_sd_dirty
);
    logic [NUM_LVL-1:0]            wr_mask, wr_base, en_nxt;
    logic                          wr_ctrl, wr_any;
    logic [CTRL_W-1:0]             ctrl_rd;
    logic [NUM_LVL-1:0][XLEN-1:0]  mask_q, base_q, mask_nxt, base_nxt;

    always_comb begin
        wr_ctrl = csr_we && (csr_addr == ADDR_W'(ADDR_CTRL));
        wr_any  = csr_we && (csr_addr < ADDR_W'(ADDR_LIMIT));
        for (int l = 0; l < NUM_LVL; l++) begin
            wr_mask[l] = csr_we && (csr_addr == ADDR_W'(ADDR_FIRST + 2 * l));
            wr_base[l] = csr_we && (csr_addr == ADDR_W'(ADDR_FIRST + 2 * l + 1));
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (csr_addr == ADDR_W'(ADDR_CTRL)) csr_rdata = XLEN'(ctrl_rd);
        for (int l = 0; l < NUM_LVL; l++) begin
            if (csr_addr == ADDR_W'(ADDR_FIRST + 2 * l))     csr_rdata = mask_q[l];
            if (csr_addr == ADDR_W'(ADDR_FIRST + 2 * l + 1)) csr_rdata = base_q[l];
        end
    end

    ptrmask_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_any    (wr_any),
        .wen_val   (csr_wdata[BIT_EN_LO +: NUM_LVL]),
        .wmcur_val (csr_wdata[BIT_MCUR]),
        .en_nxt    (en_nxt),
        .ctrl_rd   (ctrl_rd),
        .xs_flag   (st_xs_dirty),
        .sd_flag   (st_sd_dirty)
    );

    ptrmask_bank #(.XLEN(XLEN), .NUM_LVL(NUM_LVL)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mask  (wr_mask),
        .wr_base  (wr_base),
        .wdata    (csr_wdata),
        .mask_q   (mask_q),
        .base_q   (base_q),
        .mask_nxt (mask_nxt),
        .base_nxt (base_nxt)
    );

    ptrmask_select #(.XLEN(XLEN)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv        (priv),
        .xlen32      (xlen32),
        .ext_present (ext_present),
        .en_nxt      (en_nxt),
        .mask_nxt    (mask_nxt),
        .base_nxt    (base_nxt),
        .cur_mask    (cur_mask),
        .cur_base    (cur_base)
    );

    AST_INSN_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_W'(ADDR_CTRL)) |-> (csr_rdata[BIT_INSN_LO +: NUM_LVL] == '0)); // R10
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr >= ADDR_W'(ADDR_LIMIT)) |-> (csr_rdata == '0)); // R11
    AST_UNMAPPED_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && (csr_addr >= ADDR_W'(ADDR_LIMIT)) && !st_xs_dirty) |=> !st_xs_dirty); // R11
endmodule

// File: tb/sim_ptrmask_csr_bank.sv
`timescale 1ns/1ps
module sim_ptrmask_csr_bank;
    localparam real HALF_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [1:0]  priv = 2'b11;
    logic        xlen32 = 1'b0;
    logic        ext_present = 1'b1;
    logic [63:0] cur_mask, cur_base;
    logic        st_xs_dirty, st_sd_dirty;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] mask;
        logic [63:0] base;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    logic [63:0] m_mask [3];
    logic [63:0] m_base [3];
    logic [2:0]  m_en = '0;
    logic        m_mcur = 1'b1;
    logic        m_dirty = 1'b0;

    always #(HALF_NS) clk = ~clk;

    ptrmask_csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .priv(priv),
        .xlen32(xlen32), .ext_present(ext_present), .cur_mask(cur_mask),
        .cur_base(cur_base), .st_xs_dirty(st_xs_dirty), .st_sd_dirty(st_sd_dirty)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ctrl_exp();
        return {55'b0, m_mcur, (m_dirty ? 2'b11 : 2'b01), 3'b000, m_en};
    endfunction

    function automatic exp_t model_pair(input string tag);
        exp_t e;
        int l;
        e.mask = '1; e.base = '0; e.tag = tag;
        l = (priv == 2'b11) ? 0 : (priv == 2'b01) ? 1 : (priv == 2'b00) ? 2 : -1;
        if (ext_present && l >= 0 && m_en[l]) begin
            e.mask = m_mask[l];
            e.base = m_base[l];
        end
        if (xlen32) begin
            e.mask[63:32] = '0;
            e.base[63:32] = '0;
        end
        return e;
    endfunction

    task automatic drive(input logic [1:0] p, input logic x32, input logic ep,
                         input logic we, input logic [2:0] a, input logic [63:0] d,
                         input string tag);
        @(negedge clk);
        priv = p; xlen32 = x32; ext_present = ep;
        csr_we = we; csr_addr = a; csr_wdata = d;
        if (we && a != 3'd7) begin
            m_dirty = 1'b1;
            if (a == 3'd0) begin
                m_en = d[2:0];
                m_mcur = d[8];
            end else if (a[0]) m_mask[(a - 1) / 2] = d;
            else               m_base[(a - 1) / 2] = d;
        end
        sb_q.push_back(model_pair(tag));
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [63:0] exp, input string tag);
        @(negedge clk);
        csr_we = 1'b0; csr_addr = a;
        sb_q.push_back(model_pair(tag));
        #1;
        check64({tag, " readback"}, csr_rdata, exp);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check64({e.tag, " cur_mask"}, cur_mask, e.mask);
                check64({e.tag, " cur_base"}, cur_base, e.base);
            end
        end
    end

    initial begin : watchdog
        #(8.0 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 3; i++) begin
            m_mask[i] = '0;
            m_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check64("R1 mask", cur_mask, '1);
        check64("R1 base", cur_base, '0);
        check64("R1 ctrl", csr_rdata, 64'h140);
        check64("R1 flags", {62'b0, st_xs_dirty, st_sd_dirty}, '0);
        rst_n = 1'b1;

        // R11: unmapped write has no effect
        drive(2'b11, 0, 1, 1, 3'd7, '1, "R11");
        rd_check(3'd0, 64'h140, "R11 ctrl");
        check64("R11 flags", {62'b0, st_xs_dirty, st_sd_dirty}, '0);
        rd_check(3'd7, '0, "R11 read");

        // R4: writes while all levels disabled keep identity
        drive(2'b11, 0, 1, 1, 3'd1, 64'hA5A5_0000_1234_5670, "R4");
        drive(2'b11, 0, 1, 1, 3'd2, 64'h0000_0040_0000_1000, "R4");
        drive(2'b11, 0, 1, 1, 3'd3, 64'h00FF_FF00_0F0F_0F00, "R4");
        drive(2'b11, 0, 1, 1, 3'd4, 64'h1111_0000_2222_0000, "R4");
        drive(2'b11, 0, 1, 1, 3'd5, 64'hF000_0000_FFFF_F000, "R4");
        drive(2'b11, 0, 1, 1, 3'd6, 64'h0000_0001_8000_0000, "R4");
        check64("R9 flags", {62'b0, st_xs_dirty, st_sd_dirty}, 64'h3);

        // R2: readback of each register
        for (int a = 1; a <= 6; a++)
            rd_check(3'(a), (a % 2 == 1) ? m_mask[(a - 1) / 2] : m_base[(a - 1) / 2], "R2");

        // R10: enable all levels, try to set instruction bits
        drive(2'b11, 0, 1, 1, 3'd0, 64'h3F, "R10");
        rd_check(3'd0, 64'h0C7, "R10 ctrl");

        // R3 / R7: select by level
        drive(2'b11, 0, 1, 0, 3'd0, '0, "R3");
        drive(2'b01, 0, 1, 0, 3'd0, '0, "R7");
        drive(2'b00, 0, 1, 0, 3'd0, '0, "R7");
        // R5: reserved encoding
        drive(2'b10, 0, 1, 0, 3'd0, '0, "R5");
        // R6: 32-bit truncation
        drive(2'b00, 1, 1, 0, 3'd0, '0, "R6");
        drive(2'b11, 1, 1, 0, 3'd0, '0, "R6");
        drive(2'b11, 0, 1, 0, 3'd0, '0, "R7");
        // R4: extension absent
        drive(2'b11, 0, 0, 0, 3'd0, '0, "R4");
        drive(2'b11, 0, 1, 0, 3'd0, '0, "R3");

        // R8: write active enabled level
        drive(2'b11, 0, 1, 1, 3'd1, 64'h0123_4567_89AB_CDEF, "R8");
        // R8: switch to supervisor and write its mask in the same cycle
        drive(2'b01, 0, 1, 1, 3'd3, 64'hFEDC_BA98_7654_3210, "R8");
        // R7: disable active supervisor level via control write
        drive(2'b01, 0, 1, 1, 3'd0, 64'h5, "R7");
        rd_check(3'd0, 64'h0C5, "R9 ctrl");
        // R8: inactive-level write leaves pair unchanged
        drive(2'b11, 0, 1, 0, 3'd0, '0, "R8");
        drive(2'b11, 0, 1, 1, 3'd6, 64'h0000_0000_0000_0ABC, "R8");
        drive(2'b11, 0, 1, 0, 3'd0, '0, "R8");

        repeat (3) @(negedge clk);
        check64("queue drained", 64'(sb_q.size()), '0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule